// File: doc/BRIEF.md
# Accumulator ALU with Stored Condition Flags

This block is the arithmetic core of a small accumulator machine. Each clock it takes two unsigned operands and a two-bit operation code, and it registers a result. The result comes from an adder or a subtractor, or it is the first operand passed through unchanged. Alongside the result it forms five status bits: sign, carry, and the greater/equal/less outcome of an unsigned magnitude comparison. These bits go into a flag register.

A two-bit select input picks one of carry, greater, equal or less and drives it onto a single condition line. The instruction sequencer uses that line to decide conditional jumps. The stored sign bit has its own output for a jump-on-negative. The flag register is written only by compare, add and subtract. An idle cycle leaves it alone, so a branch can come several cycles after the instruction that set the flags.

Top module: `alu_flag_unit`

## Requirements
- R1: With op code 2'b10 (add), z_o one clock later equals (x_i + y_i) modulo 2^16.
- R2: With op code 2'b11 (subtract) or 2'b01 (compare), z_o one clock later equals (x_i - y_i) modulo 2^16.
- R3: With op code 2'b00 (no operation), z_o one clock later equals x_i. The flag register keeps its previous value, which is seen through neg_o and through cond_o for every select code.
- R4: After an add, the stored carry is the carry out of bit 15 of the 17-bit sum.
- R5: After a subtract or compare, the stored carry is 1 exactly when x_i >= y_i (unsigned), meaning no borrow.
- R6: After an add, subtract or compare, neg_o equals bit 15 of the new z_o.
- R7: After an add, subtract or compare, the stored greater, equal and less flags equal x_i > y_i, x_i == y_i and x_i < y_i (unsigned). Exactly one of them is high.
- R8: cond_o follows fsel_i without a clock: code 0 gives carry, 1 gives greater, 2 gives equal, 3 gives less.
- R9: A clock edge with rst_i high clears z_o and every flag, whatever the op code. cond_o is then 0 for every select code and neg_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| x_i | input | 16 | First operand (accumulator side) |
| y_i | input | 16 | Second operand (memory side) |
| op_i | input | 2 | 00 none, 01 compare, 10 add, 11 subtract |
| fsel_i | input | 2 | Condition select: 0 carry, 1 greater, 2 equal, 3 less |
| z_o | output | 16 | Registered result |
| neg_o | output | 1 | Stored sign flag |
| cond_o | output | 1 | Selected stored flag |

## Verification
Several operand pairs are used for add, and each shows something different. Small values show plain addition. 0xFFFF plus 1 shows carry-out together with a zero result. 0x7FFF plus 1 shows the sign bit set without a carry. For subtract and compare, the bench uses operand pairs that are equal, smaller-first and larger-first. One of these pairs has 0x8000 against 0x0001, where an unsigned compare and a signed compare give opposite answers. These pairs tell the no-borrow carry apart from a raw borrow, and tell each one-hot greater/equal/less outcome apart from the others. Idle cycles placed between flag-setting operations, and a reset applied while an add is presented, show that the flags hold, and that reset overrides the operation.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CMP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_CARRY = 2'd0,
    SEL_GT    = 2'd1,
    SEL_EQ    = 2'd2,
    SEL_LT    = 2'd3
  } cond_sel_e;

  // bit order: 4 sign, 3 carry, 2 greater, 1 equal, 0 less
  typedef struct packed {
    logic sign;
    logic carry;
    logic gt;
    logic eq;
    logic lt;
  } status_t;

  localparam int unsigned STATUS_BITS = $bits(status_t);

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_flag_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output status_t      stat_o
);

  localparam int unsigned EW = W + 1;

  logic [EW-1:0] sum_ext;
  logic [EW-1:0] dif_ext;
  logic          use_sub;

  assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
  assign dif_ext = {1'b0, a_i} - {1'b0, b_i};
  assign use_sub = op_i[0];

  always_comb begin
    if (op_i == OP_NONE) begin
      res_o = a_i;
    end else if (use_sub) begin
      res_o = dif_ext[W-1:0];
    end else begin
      res_o = sum_ext[W-1:0];
    end
    stat_o.sign  = res_o[W-1];
    stat_o.carry = use_sub ? ~dif_ext[W] : sum_ext[W];
    stat_o.gt    = a_i > b_i;
    stat_o.eq    = a_i == b_i;
    stat_o.lt    = a_i < b_i;
  end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_flag_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  logic    load_i,
  input  status_t d_i,
  output status_t q_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/alu_cond_mux.sv
module alu_cond_mux
  import alu_flag_pkg::*;
(
  input  status_t   flags_i,
  input  cond_sel_e sel_i,
  output logic      cond_o
);

  localparam int unsigned NSEL = 4;

  logic [NSEL-1:0] cand;

  assign cand[SEL_CARRY] = flags_i.carry;
  assign cand[SEL_GT]    = flags_i.gt;
  assign cand[SEL_EQ]    = flags_i.eq;
  assign cand[SEL_LT]    = flags_i.lt;

  assign cond_o = cand[sel_i];

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [1:0]   op_i,
  input  logic [1:0]   fsel_i,
  output logic [W-1:0] z_o,
  output logic         neg_o,
  output logic         cond_o
);

  alu_op_e      op_e;
  logic [W-1:0] res_d;
  status_t      stat_d;
  status_t      flag_q;
  logic         flag_we;

  assign op_e    = alu_op_e'(op_i);
  assign flag_we = op_e != OP_NONE;

  alu_arith #(.W(W)) u_arith (
    .a_i    (x_i),
    .b_i    (y_i),
    .op_i   (op_e),
    .res_o  (res_d),
    .stat_o (stat_d)
  );

  alu_status_reg u_flags (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (flag_we),
    .d_i    (stat_d),
    .q_o    (flag_q)
  );

  alu_cond_mux u_cond (
    .flags_i (flag_q),
    .sel_i   (cond_sel_e'(fsel_i)),
    .cond_o  (cond_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      z_o <= '0;
    end else begin
      z_o <= res_d;
    end
  end

  assign neg_o = flag_q.sign;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] z_o,
  input logic         neg_o,
  input logic [4:0]   flags_i
);

  p_add_result_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 2'b10) |=> (z_o == W'($past(x_i) + $past(y_i))));

  p_sub_result_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i[0] == 1'b1) |=> (z_o == W'($past(x_i) - $past(y_i))));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 2'b00) |=> ($stable(flags_i) && z_o == $past(x_i)));

  p_sign_follows_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i != 2'b00) |=> (neg_o == z_o[W-1]));

  p_compare_onehot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i != 2'b00) |=> ($countones(flags_i[2:0]) == 1));

  p_reset_clear_r9: assert property (@(posedge clk_i)
    rst_i |=> (z_o == '0 && flags_i == '0));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .x_i     (x_i),
  .y_i     (y_i),
  .op_i    (op_i),
  .z_o     (z_o),
  .neg_o   (neg_o),
  .flags_i (flag_q)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x = '0;
  logic [15:0] y = '0;
  logic [1:0]  op = 2'b00;
  logic [1:0]  fsel = 2'b00;
  logic [15:0] z;
  logic        neg;
  logic        cond;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] z;
    logic        n, c, g, e, l;
    string       tag;
  } exp_t;

  exp_t exq[$];

  // reference flag state
  logic mn = 0, mc = 0, mg = 0, me = 0, ml = 0;

  always #5 clk = ~clk;

  alu_flag_unit #(.W(16)) i_alu_flag_unit (
    .clk_i  (clk),
    .rst_i  (rst),
    .x_i    (x),
    .y_i    (y),
    .op_i   (op),
    .fsel_i (fsel),
    .z_o    (z),
    .neg_o  (neg),
    .cond_o (cond)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // cycle the condition select over all four codes
  task automatic check_cond(input logic c, g, e, l, input string tag);
    logic [3:0] ex;
    ex = {l, e, g, c};
    for (int s = 0; s < 4; s++) begin
      fsel = 2'(s);
      #1;
      check(cond == ex[s], tag, $sformatf("cond sel=%0d (R8)", s), int'(cond), int'(ex[s]));
    end
  endtask

  // driver: present one operation and push its expectation
  task automatic drive(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                       input string tag);
    exp_t it;
    logic [16:0] s17;
    @(negedge clk);
    x = a; y = b; op = o;
    case (o)
      2'b00: it.z = a;
      2'b10: begin s17 = {1'b0, a} + {1'b0, b}; it.z = s17[15:0]; mc = s17[16]; end
      default: begin it.z = a - b; mc = (a >= b); end
    endcase
    if (o != 2'b00) begin
      mn = it.z[15]; mg = a > b; me = a == b; ml = a < b;
    end
    it.n = mn; it.c = mc; it.g = mg; it.e = me; it.l = ml; it.tag = tag;
    exq.push_back(it);
  endtask

  // monitor: compare what the design produced one edge after the drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exq.size() > 0) begin
        exp_t it;
        it = exq.pop_front();
        check(z == it.z, it.tag, "z_o", int'(z), int'(it.z));
        check(neg == it.n, it.tag, "neg_o (R6)", int'(neg), int'(it.n));
        check_cond(it.c, it.g, it.e, it.l, it.tag);
      end
    end
  end

  task automatic drain;
    @(negedge clk);
    op = 2'b00;
    while (exq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check(z == 16'h0, "R9", "z_o after reset", int'(z), 0);
    check(neg == 1'b0, "R9", "neg_o after reset", int'(neg), 0);
    check_cond(1'b0, 1'b0, 1'b0, 1'b0, "R9");

    drive(2'b10, 16'h0001, 16'h0002, "R1");   // plain add
    drive(2'b10, 16'hFFFF, 16'h0001, "R4");   // carry out, zero result
    drive(2'b10, 16'h7FFF, 16'h0001, "R6");   // sign set, no carry
    drive(2'b00, 16'h1234, 16'h9999, "R3");   // idle: z=x, flags kept
    drive(2'b11, 16'h0005, 16'h0003, "R2");   // sub, no borrow
    drive(2'b11, 16'h0003, 16'h0005, "R5");   // sub with borrow, negative
    drive(2'b01, 16'h00AA, 16'h00AA, "R7");   // compare equal
    drive(2'b01, 16'h0002, 16'h0009, "R7");   // compare less
    drive(2'b01, 16'h8000, 16'h0001, "R7");   // unsigned greater
    drive(2'b00, 16'h0F0F, 16'h0000, "R3");   // idle keeps greater
    drive(2'b00, 16'h0000, 16'hFFFF, "R3");   // second idle
    drive(2'b10, 16'h8000, 16'h8000, "R4");   // carry, zero, equal
    drive(2'b11, 16'h0000, 16'h0000, "R5");   // equal sub sets carry
    drain();

    // reset while an add is presented
    @(negedge clk);
    rst = 1'b1; x = 16'hF000; y = 16'h0F00; op = 2'b10;
    @(negedge clk);
    rst = 1'b0; op = 2'b00;
    #1;
    check(z == 16'h0, "R9", "z_o after mid-run reset", int'(z), 0);
    check(neg == 1'b0, "R9", "neg_o after mid-run reset", int'(neg), 0);
    check_cond(1'b0, 1'b0, 1'b0, 1'b0, "R9");
    mn = 0; mc = 0; mg = 0; me = 0; ml = 0;

    drive(2'b10, 16'hC000, 16'h4000, "R1");
    drive(2'b11, 16'h1000, 16'h0FFF, "R2");
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule